// File: doc/BRIEF.md
# Fully Associative Branch Target Table

This block sits beside an instruction prefetch unit and predicts redirections. Every cycle the prefetcher presents the address it is about to fetch. The block compares that address against the branch address stored in every valid slot at once. On a match it returns the stored target, and prefetching jumps there. On no match, prefetching carries on with the next sequential instruction. No direction history is kept: if a branch is in the table, it is predicted taken.

When a branch executes, its address, its outcome and its actual target arrive on a resolution port. The block then adjusts its contents:
- A first-time taken branch is installed.
- A branch that was present but did not go is dropped.
- A branch whose destination moved has its stored target replaced.

In the same cycle the block states whether the table had the branch wrong. If it did, it gives the address the prefetcher must restart from. When a new branch must be installed, an empty slot is used first. If there is none, the least recently used slot is evicted.

Top module: `fa_target_table`

## Requirements
- R1: With `lk_valid` high and `lk_addr` equal to a valid slot's branch address, the same cycle shows `lk_hit`=1, `lk_target` = that slot's target and `lk_index` = the slot number. Otherwise `lk_hit`=0, `lk_target`=0 and `lk_index`=0.
- R2: `lk_next` equals `lk_target` on a hit and `lk_addr`+4 on a miss.
- R3: A resolved taken branch (`rs_taken`=1) that is not in the table is installed. It goes into the lowest-numbered empty slot when one exists.
- R4: A resolved not-taken branch that is not in the table changes nothing.
- R5: A resolved not-taken branch that is in the table has its slot emptied.
- R6: A resolved taken branch that is in the table keeps its slot, with the stored target set to `rs_target`.
- R7: When the table is full, installation evicts the slot least recently used. A use is an install, a taken resolution that hits, or a lookup hit.
- R8: While `rs_valid` is high, `fix_valid` is 1 in the same cycle exactly when the outcome disagrees with the current contents. The cases are: taken but absent, not taken but present, or taken to a different target. `fix_addr` is then `rs_target` if taken, else `rs_pc`+4.
- R9: A lookup in the same cycle as a resolution sees the contents from before that resolution. The change is visible on the following cycle.
- R10: After reset every slot is empty, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | AW | Prefetch address to look up |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_target | output | AW | Predicted target on a hit, else 0 |
| lk_index | output | IW | Matching slot on a hit, else 0 |
| lk_next | output | AW | Next prefetch address (target or sequential) |
| rs_valid | input | 1 | A branch resolved this cycle |
| rs_pc | input | AW | Address of the resolved branch |
| rs_taken | input | 1 | Resolved outcome, 1 = taken |
| rs_target | input | AW | Actual target of the resolved branch |
| fix_valid | output | 1 | Table prediction was wrong; restart needed |
| fix_addr | output | AW | Restart address for the prefetcher |

## Verification
The hardest condition to reach is eviction by recency. It needs a completely full table whose use order has been deliberately disturbed. The bench fills all sixteen slots in index order, which makes slot 0 the oldest. It then uses a lookup hit alone to refresh slot 0, so the next install must displace slot 1 and not slot 0. Finally it empties one slot in the middle of the full table and checks that the next install lands in that slot rather than in the victim slot.

// File: rtl/ftt_pkg.sv
package ftt_pkg;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_KILL,
        ACT_RETARGET,
        ACT_REFRESH,
        ACT_ALLOC
    } res_act_e;

    function automatic res_act_e classify(input logic vld, input logic hit,
                                          input logic taken, input logic same);
        res_act_e a;
        a = ACT_NONE;
        if (vld) begin
            if (hit && !taken)      a = ACT_KILL;
            else if (hit && !same)  a = ACT_RETARGET;
            else if (hit)           a = ACT_REFRESH;
            else if (taken)         a = ACT_ALLOC;
        end
        return a;
    endfunction

endpackage

// File: rtl/ftt_match.sv
module ftt_match #(
    parameter int N  = 16,
    parameter int AW = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_ni,
    input  logic [AW-1:0]        probe,
    input  logic [N-1:0]         valid_vec,
    input  logic [N-1:0][AW-1:0] tags,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (tags[g] == probe);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) idx = idx | IW'(i);
        end
    end

    assign hit = |hit_vec;

    // R1: tags are unique, so at most one slot can match
    a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_ni)
        $onehot0(hit_vec));

endmodule

// File: rtl/ftt_free.sv
module ftt_free #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  valid_vec,
    output logic          any_free,
    output logic [IW-1:0] free_idx
);
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IW'(i);
        end
    end

    assign any_free = ~&valid_vec;

endmodule

// File: rtl/ftt_lru.sv
module ftt_lru #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_ni,
    input  logic          ta_v,
    input  logic [IW-1:0] ta_idx,
    input  logic          tb_v,
    input  logic [IW-1:0] tb_idx,
    output logic [IW-1:0] victim
);
    typedef logic [N-1:0][IW-1:0] age_t;

    typedef struct packed {
        age_t age;
    } lru_state_t;

    lru_state_t st_d, st_q;

    function automatic age_t touch(input age_t a, input logic [IW-1:0] e);
        age_t r;
        for (int j = 0; j < N; j++) begin
            r[j] = (a[j] < a[e]) ? a[j] + IW'(1) : a[j];
        end
        r[e] = '0;
        return r;
    endfunction

    always_comb begin
        age_t mid;
        st_d = st_q;
        mid  = ta_v ? touch(st_q.age, ta_idx) : st_q.age;
        // resolution touch applied last: it becomes most recent
        st_d.age = tb_v ? touch(mid, tb_idx) : mid;
    end

    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            for (int i = 0; i < N; i++) st_q.age[i] <= IW'(N - 1 - i);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++) begin
            if (st_q.age[i] == IW'(N - 1)) victim = IW'(i);
        end
    end

    // R7: a slot touched by resolution is most recent afterwards
    a_r7_touch_mru: assert property (@(posedge clk) disable iff (!rst_ni)
        tb_v |=> st_q.age[$past(tb_idx)] == '0);

endmodule

// File: rtl/fa_target_table.sv
module fa_target_table #(
    parameter int N   = 16,
    parameter int AW  = 32,
    parameter int INC = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_ni,
    input  logic          lk_valid,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [AW-1:0] lk_target,
    output logic [IW-1:0] lk_index,
    output logic [AW-1:0] lk_next,
    input  logic          rs_valid,
    input  logic [AW-1:0] rs_pc,
    input  logic          rs_taken,
    input  logic [AW-1:0] rs_target,
    output logic          fix_valid,
    output logic [AW-1:0] fix_addr
);
    import ftt_pkg::*;

    typedef struct packed {
        logic [N-1:0]         valid;
        logic [N-1:0][AW-1:0] tag;
        logic [N-1:0][AW-1:0] tgt;
    } tab_state_t;

    tab_state_t st_d, st_q;

    logic          m_hit, r_hit, any_free;
    logic [IW-1:0] m_idx, r_idx, free_idx, victim, slot, tb_idx;
    logic          tb_v;
    res_act_e      act;

    ftt_match #(.N(N), .AW(AW)) u_lk_match (
        .clk(clk), .rst_ni(rst_ni), .probe(lk_addr),
        .valid_vec(st_q.valid), .tags(st_q.tag), .hit(m_hit), .idx(m_idx));

    ftt_match #(.N(N), .AW(AW)) u_rs_match (
        .clk(clk), .rst_ni(rst_ni), .probe(rs_pc),
        .valid_vec(st_q.valid), .tags(st_q.tag), .hit(r_hit), .idx(r_idx));

    ftt_free #(.N(N)) u_free (
        .valid_vec(st_q.valid), .any_free(any_free), .free_idx(free_idx));

    ftt_lru #(.N(N)) u_lru (
        .clk(clk), .rst_ni(rst_ni),
        .ta_v(lk_hit), .ta_idx(m_idx),
        .tb_v(tb_v), .tb_idx(tb_idx),
        .victim(victim));

    // lookup path: reads registered contents only
    always_comb begin
        lk_hit    = lk_valid && m_hit;
        lk_target = lk_hit ? st_q.tgt[m_idx] : '0;
        lk_index  = lk_hit ? m_idx : '0;
        lk_next   = lk_hit ? lk_target : lk_addr + AW'(INC);
    end

    // resolution path
    always_comb begin
        act       = classify(rs_valid, r_hit, rs_taken, st_q.tgt[r_idx] == rs_target);
        slot      = any_free ? free_idx : victim;
        fix_valid = (act == ACT_KILL) || (act == ACT_RETARGET) || (act == ACT_ALLOC);
        fix_addr  = !rs_valid ? '0 : (rs_taken ? rs_target : rs_pc + AW'(INC));
        tb_v      = (act == ACT_RETARGET) || (act == ACT_REFRESH) || (act == ACT_ALLOC);
        tb_idx    = (act == ACT_ALLOC) ? slot : r_idx;
    end

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_KILL:     st_d.valid[r_idx] = 1'b0;
            ACT_RETARGET: st_d.tgt[r_idx]   = rs_target;
            ACT_ALLOC: begin
                st_d.valid[slot] = 1'b1;
                st_d.tag[slot]   = rs_pc;
                st_d.tgt[slot]   = rs_target;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            st_q.valid <= '0;
            st_q.tag   <= '0;
            st_q.tgt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a not-taken hit empties its slot
    a_r5_kill: assert property (@(posedge clk) disable iff (!rst_ni)
        (rs_valid && !rs_taken && r_hit) |=> !st_q.valid[$past(r_idx)]);

    // R6: a taken hit leaves the resolved target stored
    a_r6_retarget: assert property (@(posedge clk) disable iff (!rst_ni)
        (rs_valid && rs_taken && r_hit) |=>
            (st_q.valid[$past(r_idx)] && st_q.tgt[$past(r_idx)] == $past(rs_target)));

    // R3: a taken miss is present in the chosen slot afterwards
    a_r3_install: assert property (@(posedge clk) disable iff (!rst_ni)
        (rs_valid && rs_taken && !r_hit) |=>
            (st_q.valid[$past(slot)] && st_q.tag[$past(slot)] == $past(rs_pc)));

    // R4: a not-taken miss leaves the valid set untouched
    a_r4_no_change: assert property (@(posedge clk) disable iff (!rst_ni)
        (rs_valid && !rs_taken && !r_hit) |=> st_q.valid == $past(st_q.valid));

endmodule

// File: tb/fa_target_table_bench.sv
module fa_target_table_bench;
    localparam int N  = 16;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit;
    logic [AW-1:0] lk_target;
    logic [3:0]    lk_index;
    logic [AW-1:0] lk_next;
    logic          rs_valid = 1'b0;
    logic [AW-1:0] rs_pc = '0;
    logic          rs_taken = 1'b0;
    logic [AW-1:0] rs_target = '0;
    logic          fix_valid;
    logic [AW-1:0] fix_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fa_target_table #(.N(N), .AW(AW)) u_fa_target_table (
        .clk(clk), .rst_ni(rst_ni),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_target(lk_target), .lk_index(lk_index), .lk_next(lk_next),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .rs_target(rs_target), .fix_valid(fix_valid), .fix_addr(fix_addr));

    typedef struct packed {
        logic        rs_v;
        logic [31:0] rs_pc;
        logic        rs_tk;
        logic [31:0] rs_tg;
        logic [31:0] lk_a;
        logic        e_hit;
        logic [31:0] e_tgt;
        logic [3:0]  e_idx;
        logic [31:0] e_next;
        logic        e_fix;
        logic [31:0] e_fixa;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VEC [11] = '{
        // R3 R8 R9: first taken is a miss, install, restart at target
        '{1'b1, 32'h100, 1'b1, 32'h500, 32'h100, 1'b0, 32'h0,   4'd0, 32'h104, 1'b1, 32'h500, 4'd3},
        // R1 R2: hit returns stored target
        '{1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 32'h500, 4'd0, 32'h500, 1'b0, 32'h0,   4'd1},
        // R8: same target taken again, no fix; R2 miss is sequential
        '{1'b1, 32'h100, 1'b1, 32'h500, 32'h104, 1'b0, 32'h0,   4'd0, 32'h108, 1'b0, 32'h0,   4'd8},
        // R6 R9: target moves, lookup sees old target this cycle
        '{1'b1, 32'h100, 1'b1, 32'h700, 32'h100, 1'b1, 32'h500, 4'd0, 32'h500, 1'b1, 32'h700, 4'd6},
        // R6: new target visible
        '{1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 32'h700, 4'd0, 32'h700, 1'b0, 32'h0,   4'd6},
        // R5 R8: not taken hit, fix to fall-through
        '{1'b1, 32'h100, 1'b0, 32'h0,   32'h100, 1'b1, 32'h700, 4'd0, 32'h700, 1'b1, 32'h104, 4'd5},
        // R5: entry gone
        '{1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b0, 32'h0,   4'd0, 32'h104, 1'b0, 32'h0,   4'd5},
        // R4 R8: not taken miss, no fix
        '{1'b1, 32'h200, 1'b0, 32'h0,   32'h200, 1'b0, 32'h0,   4'd0, 32'h204, 1'b0, 32'h0,   4'd4},
        // R4: still absent
        '{1'b0, 32'h0,   1'b0, 32'h0,   32'h200, 1'b0, 32'h0,   4'd0, 32'h204, 1'b0, 32'h0,   4'd4},
        // R3: taken miss goes into lowest empty slot (0)
        '{1'b1, 32'h300, 1'b1, 32'h900, 32'h300, 1'b0, 32'h0,   4'd0, 32'h304, 1'b1, 32'h900, 4'd3},
        // R3: installed at slot 0
        '{1'b0, 32'h0,   1'b0, 32'h0,   32'h300, 1'b1, 32'h900, 4'd0, 32'h900, 1'b0, 32'h0,   4'd3}
    };

    task automatic chk(input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic rv, input logic [31:0] pc, input logic tk,
                         input logic [31:0] tg, input logic lv, input logic [31:0] la);
        @(negedge clk);
        rs_valid = rv; rs_pc = pc; rs_taken = tk; rs_target = tg;
        lk_valid = lv; lk_addr = la;
        #2;
    endtask

    task automatic look(input int rq, input logic [31:0] a, input logic eh,
                        input logic [31:0] et, input logic [3:0] ei);
        drive(1'b0, 0, 1'b0, 0, 1'b1, a);
        chk(rq, "lk_hit", 32'(lk_hit), 32'(eh));
        chk(rq, "lk_target", lk_target, et);
        chk(rq, "lk_index", 32'(lk_index), 32'(ei));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0; rs_valid = 1'b0; lk_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_ni = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: empty after reset
        look(10, 32'h100, 1'b0, 32'h0, 4'd0);
        chk(10, "lk_next", lk_next, 32'h104);
        // R1: lk_valid low never hits
        drive(1'b1, 32'h40, 1'b1, 32'h80, 1'b0, 32'h0);
        drive(1'b0, 0, 1'b0, 0, 1'b0, 32'h40);
        chk(1, "lk_hit gated", 32'(lk_hit), 32'h0);
        look(1, 32'h40, 1'b1, 32'h80, 4'd0);
        do_reset();

        for (int i = 0; i < 11; i++) begin
            drive(VEC[i].rs_v, VEC[i].rs_pc, VEC[i].rs_tk, VEC[i].rs_tg, 1'b1, VEC[i].lk_a);
            chk(VEC[i].rq, "vec lk_hit", 32'(lk_hit), 32'(VEC[i].e_hit));
            chk(VEC[i].rq, "vec lk_target", lk_target, VEC[i].e_tgt);
            chk(VEC[i].rq, "vec lk_index", 32'(lk_index), 32'(VEC[i].e_idx));
            chk(VEC[i].rq, "vec lk_next", lk_next, VEC[i].e_next);
            chk(VEC[i].rq, "vec fix_valid", 32'(fix_valid), 32'(VEC[i].e_fix));
            if (VEC[i].e_fix) chk(VEC[i].rq, "vec fix_addr", fix_addr, VEC[i].e_fixa);
        end

        // R10: reset clears an occupied table
        do_reset();
        look(10, 32'h300, 1'b0, 32'h0, 4'd0);

        // R7: fill every slot in order, slot 0 becomes oldest
        for (int i = 0; i < N; i++)
            drive(1'b1, 32'h1000 + 32'(i) * 32'h10, 1'b1, 32'h8000 + 32'(i), 1'b0, 32'h0);
        look(7, 32'h1000, 1'b1, 32'h8000, 4'd0);   // lookup hit refreshes slot 0
        drive(1'b1, 32'h2000, 1'b1, 32'hA000, 1'b0, 32'h0);
        look(7, 32'h1010, 1'b0, 32'h0, 4'd0);      // slot 1 evicted
        look(7, 32'h1000, 1'b1, 32'h8000, 4'd0);   // slot 0 kept
        look(7, 32'h2000, 1'b1, 32'hA000, 4'd1);   // new branch in slot 1

        // R5 then R3: empty slot 5 of a full table, next install uses it
        drive(1'b1, 32'h1050, 1'b0, 32'h0, 1'b0, 32'h0);
        look(5, 32'h1050, 1'b0, 32'h0, 4'd0);
        drive(1'b1, 32'h3000, 1'b1, 32'hB000, 1'b0, 32'h0);
        look(3, 32'h3000, 1'b1, 32'hB000, 4'd5);
        look(7, 32'h1020, 1'b1, 32'h8002, 4'd2);   // slot 2 still present

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule